// File: doc/BRIEF.md
# Latched-Address One-Time-Programmable Read Memory

This block is a synthesizable cycle model of an 8192-word by 8-bit one-time-programmable read memory. A read cycle opens when the active-low chip enable is seen low after being high. On that clock edge the word address is captured into an internal register, and the register holds it until the chip enable goes high again. The address bus is therefore free to carry other traffic for the rest of the cycle, as on a shared address/data bus. After a fixed number of clocks the data for the captured address is flagged valid. The active-low output enable decides whether the output is driven. The output's three-state condition is shown by a drive flag rather than by real high-impedance pins.

Storage is a square matrix of 256 rows of 256 fuse bits. The upper address bits choose one row. The low five address bits choose one column inside each of eight 32-column groups, and group b feeds data bit b. Every cell starts at 0 and can only be set to 1. A programming write ORs a mask into one word. It is taken only while the program enable is high and the device is deselected.

Top module: `prom_latched_otp`

## Requirements
- R1: After reset every word reads 0x00, and rd_drive and rd_valid are 0.
- R2: The word address (binary, 0 to 8191 on addr) is captured on the first clock edge at which ce_n is sampled low after being high. Changes on addr later in that enabled cycle do not change rd_data.
- R3: rd_valid rises READ_LAT clock edges after the capturing edge, counting the capturing edge as the first (default 2). Until then rd_valid is 0 and rd_data is 0x00.
- R4: With the cycle active and oe_n low, rd_drive is 1 and rd_data shows the word at the captured address.
- R5: With the cycle active and oe_n high, rd_drive is 0 and rd_data is 0x00. The cycle stays active, so lowering oe_n again shows the same word with no new capture.
- R6: One clock edge after ce_n is sampled high, rd_drive and rd_valid are 0 whatever oe_n is.
- R7: A program write on a clock edge with prog_en=1, prog_we=1 and ce_n=1 sets to 1 every bit of the word at addr whose prog_mask bit is 1. Mask bit b maps to data bit b.
- R8: Programming a bit that is already 1 has no effect. A mask bit of 0 never clears a stored 1.
- R9: A program write is ignored when prog_en is 0, or when ce_n is low or the device is still selected.
- R10: A program write changes only the addressed word. Words that share its row or its column keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, clears the array |
| addr | input | 13 | Word address for reads and program writes |
| ce_n | input | 1 | Active-low chip enable; falling sample opens a read cycle |
| oe_n | input | 1 | Active-low output enable |
| prog_en | input | 1 | Program enable |
| prog_we | input | 1 | Program write strobe |
| prog_mask | input | 8 | Bits to set to 1 at addr |
| rd_data | output | 8 | Read data, 0x00 when not driven or not yet valid |
| rd_drive | output | 1 | 1 when the outputs would be driven, 0 for high impedance |
| rd_valid | output | 1 | Read data valid for the captured address |

## Verification
The bench scrambles the address bus right after the capturing edge. A model that reads through the live bus instead of the held register returns the complemented address's word. It samples one clock before the latency expires, which catches a valid flag raised early or late. It also toggles oe_n inside an active cycle, so a model that ends the cycle on a high output enable, or that drives data anyway, shows the wrong drive flag or a lost word. Program writes are sent with prog_en low and with the chip selected, with empty and overlapping masks, and to row and column neighbours. A model that gates programming wrongly, clears bits, or decodes a row or column wrongly then reads back a value that differs from the bench's shadow copy.

// File: rtl/prom_lat_pkg.sv
package prom_lat_pkg;
   localparam int unsigned DEF_ADDR_W   = 13;
   localparam int unsigned DEF_DATA_W   = 8;
   localparam int unsigned DEF_ROW_BITS = 8;
   localparam int unsigned DEF_READ_LAT = 2;

   function automatic int unsigned lat_cnt_w(input int unsigned lat);
      return (lat < 2) ? 1 : $clog2(lat + 1);
   endfunction
endpackage

// File: rtl/prom_fuse_matrix.sv
module prom_fuse_matrix #(
   parameter int unsigned ADDR_W   = 13,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned ROW_BITS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic [ADDR_W-1:0] set_addr,
   input  logic [DATA_W-1:0] set_mask,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_word
);
   localparam int unsigned COL_BITS = ADDR_W - ROW_BITS;
   localparam int unsigned ROWS     = 1 << ROW_BITS;
   localparam int unsigned GROUP    = 1 << COL_BITS;
   localparam int unsigned COLS     = DATA_W * GROUP;

   if (ROW_BITS == 0 || ROW_BITS >= ADDR_W) begin : g_bad_split
      $error("prom_fuse_matrix: ROW_BITS must lie between 1 and ADDR_W-1");
   end
   if (ROWS * COLS != (1 << ADDR_W) * DATA_W) begin : g_bad_size
      $error("prom_fuse_matrix: matrix size does not match word count");
   end

   logic [ROWS-1:0][COLS-1:0] cells;
   logic [ROW_BITS-1:0]       set_row;
   logic [COL_BITS-1:0]       set_col;
   logic [ROW_BITS-1:0]       rd_row_idx;
   logic [COL_BITS-1:0]       rd_col;
   logic [ROWS-1:0]           row_hit;
   logic [COLS-1:0]           set_vec;
   logic [COLS-1:0]           rd_row;

   assign set_row    = set_addr[ADDR_W-1:COL_BITS];
   assign set_col    = set_addr[COL_BITS-1:0];
   assign rd_row_idx = rd_addr[ADDR_W-1:COL_BITS];
   assign rd_col     = rd_addr[COL_BITS-1:0];

   // gated row decoder: one-hot write select
   for (genvar r = 0; r < ROWS; r++) begin : g_row_dec
      assign row_hit[r] = set_en && (set_row == ROW_BITS'(r));
   end

   // column expansion: mask bit b lands in group b at the selected column
   for (genvar b = 0; b < DATA_W; b++) begin : g_set_grp
      for (genvar c = 0; c < GROUP; c++) begin : g_set_col
         assign set_vec[b*GROUP + c] = set_mask[b] && (set_col == COL_BITS'(c));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cells <= '0;
      end else begin
         for (int r = 0; r < ROWS; r++) begin
            if (row_hit[r]) cells[r] <= cells[r] | set_vec;
         end
      end
   end

   assign rd_row = cells[rd_row_idx];

   // 1-of-GROUP column select per output bit
   for (genvar b = 0; b < DATA_W; b++) begin : g_rd_grp
      logic [GROUP-1:0] grp;
      assign grp        = rd_row[b*GROUP +: GROUP];
      assign rd_word[b] = grp[rd_col];
   end
endmodule

// File: rtl/prom_addr_capture.sv
module prom_addr_capture #(
   parameter int unsigned ADDR_W   = 13,
   parameter int unsigned READ_LAT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic [ADDR_W-1:0] addr,
   output logic              active,
   output logic [ADDR_W-1:0] lat_addr,
   output logic              data_ok
);
   import prom_lat_pkg::*;
   localparam int unsigned CNT_W = lat_cnt_w(READ_LAT);

   if (READ_LAT < 1) begin : g_bad_lat
      $error("prom_addr_capture: READ_LAT must be at least 1");
   end

   logic             active_q;
   logic [CNT_W-1:0] cnt_q;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
         addr_q   <= '0;
      end else if (ce_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else begin
         active_q <= 1'b1;
         if (!active_q) begin
            addr_q <= addr;
            cnt_q  <= CNT_W'(1);
         end else if (cnt_q != CNT_W'(READ_LAT)) begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   assign active   = active_q;
   assign lat_addr = addr_q;
   assign data_ok  = active_q && (cnt_q == CNT_W'(READ_LAT));
endmodule

// File: rtl/prom_out_stage.sv
module prom_out_stage #(
   parameter int unsigned DATA_W    = 8,
   parameter bit          ZERO_IDLE = 1'b1
) (
   input  logic              active,
   input  logic              oe_n,
   input  logic              data_ok,
   input  logic [DATA_W-1:0] word,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_drive,
   output logic              rd_valid
);
   assign rd_drive = active && !oe_n;
   assign rd_valid = data_ok;

   if (ZERO_IDLE) begin : g_zero_idle
      assign rd_data = (rd_drive && data_ok) ? word : '0;
   end else begin : g_pass
      assign rd_data = word;
   end
endmodule

// File: rtl/prom_latched_otp.sv
module prom_latched_otp #(
   parameter int unsigned ADDR_W    = prom_lat_pkg::DEF_ADDR_W,
   parameter int unsigned DATA_W    = prom_lat_pkg::DEF_DATA_W,
   parameter int unsigned ROW_BITS  = prom_lat_pkg::DEF_ROW_BITS,
   parameter int unsigned READ_LAT  = prom_lat_pkg::DEF_READ_LAT,
   parameter bit          ZERO_IDLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              prog_en,
   input  logic              prog_we,
   input  logic [DATA_W-1:0] prog_mask,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_drive,
   output logic              rd_valid
);
   logic              active;
   logic              data_ok;
   logic [ADDR_W-1:0] lat_addr;
   logic [DATA_W-1:0] word;
   logic              set_en;

   // programming only while deselected, both at the pin and internally
   assign set_en = prog_en && prog_we && ce_n && !active;

   prom_addr_capture #(.ADDR_W(ADDR_W), .READ_LAT(READ_LAT)) u_cap (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .addr(addr),
      .active(active), .lat_addr(lat_addr), .data_ok(data_ok)
   );

   prom_fuse_matrix #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROW_BITS(ROW_BITS)) u_mat (
      .clk(clk), .rst_n(rst_n), .set_en(set_en), .set_addr(addr),
      .set_mask(prog_mask), .rd_addr(lat_addr), .rd_word(word)
   );

   prom_out_stage #(.DATA_W(DATA_W), .ZERO_IDLE(ZERO_IDLE)) u_out (
      .active(active), .oe_n(oe_n), .data_ok(data_ok), .word(word),
      .rd_data(rd_data), .rd_drive(rd_drive), .rd_valid(rd_valid)
   );
endmodule

// File: rtl/prom_latched_otp_chk.sv
module prom_latched_otp_chk #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned READ_LAT  = 2,
   parameter bit          ZERO_IDLE = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              oe_n,
   input logic [DATA_W-1:0] rd_data,
   input logic              rd_drive,
   input logic              rd_valid
);
   logic ce_prev_q;
   int unsigned since_fall;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ce_prev_q  <= 1'b1;
         since_fall <= 0;
      end else begin
         ce_prev_q <= ce_n;
         if (ce_n) since_fall <= 0;
         else if (ce_prev_q) since_fall <= 1;
         else if (since_fall <= READ_LAT) since_fall <= since_fall + 1;
      end
   end

   AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |=> (!rd_drive && !rd_valid)); // R6
   AST_OE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !rd_drive); // R5
   AST_VALID_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(!ce_n)); // R3
   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_valid) |-> (since_fall == READ_LAT)); // R3
   AST_HELD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && $past(rd_valid) && rd_drive && $past(rd_drive)) |-> $stable(rd_data)); // R2

   if (ZERO_IDLE) begin : g_idle_chk
      AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         !(rd_drive && rd_valid) |-> (rd_data == '0)); // R3
   end
endmodule

bind prom_latched_otp prom_latched_otp_chk #(
   .DATA_W(DATA_W), .READ_LAT(READ_LAT), .ZERO_IDLE(ZERO_IDLE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n),
   .rd_data(rd_data), .rd_drive(rd_drive), .rd_valid(rd_valid)
);

// File: tb/prom_latched_otp_tb.sv
module prom_latched_otp_tb;
   localparam int LAT = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [12:0] addr = '0;
   logic        ce_n = 1'b1;
   logic        oe_n = 1'b1;
   logic        prog_en = 1'b0;
   logic        prog_we = 1'b0;
   logic [7:0]  prog_mask = '0;
   logic [7:0]  rd_data;
   logic        rd_drive;
   logic        rd_valid;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   byte unsigned shadow [int];

   always #2 clk = ~clk;

   prom_latched_otp #(.READ_LAT(LAT)) u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
      .prog_en(prog_en), .prog_we(prog_we), .prog_mask(prog_mask),
      .rd_data(rd_data), .rd_drive(rd_drive), .rd_valid(rd_valid)
   );

   function automatic byte unsigned exp_word(input int a);
      return shadow.exists(a) ? shadow[a] : 8'h00;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic prog(input int a, input logic [7:0] m, input bit pe, input bit sel);
      @(negedge clk);
      ce_n = sel ? 1'b0 : 1'b1;
      prog_en = pe; prog_we = 1'b1; addr = 13'(a); prog_mask = m;
      @(negedge clk);
      prog_we = 1'b0; prog_en = 1'b0; ce_n = 1'b1; prog_mask = '0;
      if (pe && !sel) shadow[a] = exp_word(a) | m;
      @(negedge clk);
   endtask

   task automatic rd(input int a, input string req);
      byte unsigned e;
      e = exp_word(a);
      @(negedge clk);
      ce_n = 1'b0; oe_n = 1'b0; addr = 13'(a);
      @(negedge clk);
      addr = ~13'(a);                          // R2 bus changes after capture
      chk("R3 valid early", 32'(rd_valid), 0);
      chk("R3 data early", 32'(rd_data), 0);
      repeat (LAT - 1) @(negedge clk);
      chk("R3 valid", 32'(rd_valid), 1);
      chk("R4 drive", 32'(rd_drive), 1);
      chk(req, 32'(rd_data), 32'(e));
      oe_n = 1'b1; #1;
      chk("R5 hiz drive", 32'(rd_drive), 0);
      chk("R5 hiz data", 32'(rd_data), 0);
      @(negedge clk);
      oe_n = 1'b0; #1;
      chk("R5 cycle kept", 32'(rd_data), 32'(e));
      @(negedge clk);
      ce_n = 1'b1;
      @(negedge clk);
      chk("R6 drive", 32'(rd_drive), 0);
      chk("R6 valid", 32'(rd_valid), 0);
   endtask

   initial begin
      #800000;
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int pool [8];
      void'($urandom(32'd5151));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state and blank array
      chk("R1 drive", 32'(rd_drive), 0);
      chk("R1 valid", 32'(rd_valid), 0);
      rd(0, "R1 blank 0");
      rd(8191, "R1 blank top");
      rd(4660, "R1 blank mid");
      // R7 R8 set and no clear
      prog(100, 8'hF0, 1'b1, 1'b0);
      rd(100, "R7 set");
      prog(100, 8'h0F, 1'b1, 1'b0);
      rd(100, "R7 or");
      prog(100, 8'h00, 1'b1, 1'b0);
      prog(100, 8'h81, 1'b1, 1'b0);
      rd(100, "R8 no clear");
      // R9 gating
      prog(8191, 8'hFF, 1'b0, 1'b0);
      rd(8191, "R9 no prog_en");
      prog(0, 8'hA5, 1'b1, 1'b1);
      rd(0, "R9 selected");
      prog(0, 8'h5A, 1'b1, 1'b0);
      rd(0, "R7 word 0");
      // R10 neighbours: same row (99,101), same column (100+32, 100-32)
      rd(99, "R10 row nb");
      rd(101, "R10 row nb");
      rd(132, "R10 col nb");
      rd(68, "R10 col nb");
      // R2 scrambled bus with a complement that is programmed
      prog(8191 - 100, 8'h3C, 1'b1, 1'b0);
      rd(100, "R2 held addr");
      rd(8191 - 100, "R2 held addr");
      // random mix
      for (int i = 0; i < 8; i++) pool[i] = ((i * 1237) + 31) % 8192;
      for (int i = 0; i < 60; i++) begin
         int a;
         int op;
         a  = pool[$urandom % 8];
         op = $urandom % 3;
         if (op == 0) prog(a, 8'($urandom), 1'b1, 1'b0);
         else if (op == 1) prog(a, 8'($urandom), ($urandom % 2) == 1, 1'b1);
         else rd(a, "R7 random read");
      end
      for (int i = 0; i < 8; i++) rd(pool[i], "R8 final read");
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule